// File: doc/BRIEF.md
# System Control Register Bank

This block is a four-word register bank on a simple peripheral bus. A word is selected by a two-bit address, and the bus has two active-low strobes: a module select and a write strobe. The registers hold the chip-level control state. That state covers the boot-mode value sampled from input pads, the switches that send program-memory or data-memory accesses to the external memory interface, the switches that block the processor's low-power wait and stop instructions, and an 8-bit pin-function selection word. Two general-purpose 16-bit scratch words are also kept for software.

The state falls into three reset classes, each with its own lifetime. The scratch words are cleared only by power-on reset, so they survive every other reset. The control switches and the pin-function word return to zero on any reset. The boot-mode field is sampled again from the pads on power-on and system resets, but a watchdog reset leaves it unchanged. A software handler can therefore still read how the chip first started. All resets are sampled on the rising clock edge.

Top module: `sysctl_regs`

## Requirements
- R1: The bus address selects the word: 0 control, 1 pin-function, 2 scratch A, 3 scratch B. While `sel_n` is low, `rdata` shows the selected word combinationally.
- R2: While `sel_n` is high, `rdata` is all zeros and a low `wr_n` changes no register.
- R3: A register takes `wdata` at the rising edge where `sel_n` and `wr_n` are both low, and the new value is visible from the next cycle. A read (`wr_n` high) changes nothing.
- R4: The control word layout is: bits [2:0] boot mode, bit 3 program-memory redirect, bit 4 data-memory redirect, bit 5 stop-instruction block, bit 6 wait-instruction block. Bits [15:7] read as zero. Outputs `pram_ext`, `dram_ext`, `stop_block` and `wait_block` follow bits 3 to 6.
- R5: The pin-function word occupies bits [7:0] of address 1, with the upper bits reading as zero. Output `iocfg` follows it.
- R6: A low `por_n` at an edge clears every register and loads the boot field from `boot_pads`.
- R7: A low `rst_n` at an edge clears control bits 3 to 6 and the pin-function word, and reloads the boot field from `boot_pads`. The scratch words keep their values.
- R8: A low `wdog_n` at an edge clears control bits 3 to 6 and the pin-function word. The boot field and the scratch words keep their values.
- R9: A write in a cycle where any reset input is low has no effect.
- R10: Control bits [2:0] are read-only: a bus write never changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | System reset, active low, synchronous |
| wdog_n | input | 1 | Watchdog reset, active low, synchronous |
| boot_pads | input | 3 | Boot-mode pad levels |
| sel_n | input | 1 | Module select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Word select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero when not selected |
| pram_ext | output | 1 | Send program-memory accesses to the external interface |
| dram_ext | output | 1 | Send data-memory accesses to the external interface |
| stop_block | output | 1 | Block the stop instruction |
| wait_block | output | 1 | Block the wait instruction |
| iocfg | output | 8 | Pin-function selection bits |

## Verification
A register sitting in the wrong reset class is the most likely fault. It shows up on the first read after a reset pulse. Examples are a scratch word cleared by a watchdog, a boot field lost on a watchdog, or a boot field not re-sampled on a system reset. A write decode slip corrupts either the addressed word or a neighbour, and the control outputs or `iocfg` expose it one cycle after the strobe. A select leak shows up at once as a nonzero `rdata` while `sel_n` is high.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int ADDR_W   = 2;
   localparam int NUM_REGS = 1 << ADDR_W;
   localparam int FLAG_W   = 4;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL  = 2'd0,
      REG_IOCFG = 2'd1,
      REG_SWA   = 2'd2,
      REG_SWB   = 2'd3
   } reg_sel_e;

   // order of the switches inside the flag field
   localparam int FLG_PRAM = 0;
   localparam int FLG_DRAM = 1;
   localparam int FLG_STOP = 2;
   localparam int FLG_WAIT = 3;

   typedef enum logic {
      RST_POR_ONLY = 1'b0,
      RST_ANY      = 1'b1
   } rst_class_e;
endpackage

// File: rtl/sysctl_wdec.sv
module sysctl_wdec
   import sysctl_pkg::*;
#(
   parameter int N = NUM_REGS
) (
   input  logic                    sel_n,
   input  logic                    wr_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    hold,
   output logic [N-1:0]            we
);
   logic strobe;
   assign strobe = !sel_n && !wr_n && !hold;

   for (genvar i = 0; i < N; i++) begin : g_dec
      assign we[i] = strobe && (addr == ADDR_W'(i));
   end
endmodule

// File: rtl/sysctl_field.sv
module sysctl_field
   import sysctl_pkg::*;
#(
   parameter int         W   = 16,
   parameter rst_class_e CLS = RST_ANY
) (
   input  logic         clk,
   input  logic         por_n,
   input  logic         any_rst,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("sysctl_field: W must be positive");
   end

   if (CLS == RST_POR_ONLY) begin : g_por_only
      always_ff @(posedge clk) begin
         if (!por_n)
            q <= '0;
         else if (we)
            q <= d;
      end
   end else begin : g_any
      always_ff @(posedge clk) begin
         if (any_rst)
            q <= '0;
         else if (we)
            q <= d;
      end
   end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
   import sysctl_pkg::*;
#(
   parameter int W = 16,
   parameter int N = NUM_REGS
) (
   input  logic                  sel_n,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [N-1:0][W-1:0]   words,
   output logic [W-1:0]          rdata
);
   always_comb begin
      rdata = '0;
      if (!sel_n)
         rdata = words[addr];
   end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CFG_W  = 8,
   parameter int BOOT_W = 3
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              wdog_n,
   input  logic [BOOT_W-1:0] boot_pads,
   input  logic              sel_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              pram_ext,
   output logic              dram_ext,
   output logic              stop_block,
   output logic              wait_block,
   output logic [CFG_W-1:0]  iocfg
);
   localparam int FLAG_LSB = BOOT_W;
   localparam int NUM_SW   = NUM_REGS - 2;

   if (BOOT_W + FLAG_W > DATA_W) begin : g_chk_ctrl
      $error("sysctl_regs: control field does not fit the data width");
   end
   if (CFG_W > DATA_W || CFG_W < 1) begin : g_chk_cfg
      $error("sysctl_regs: CFG_W out of range");
   end

   logic                         any_rst;
   logic [NUM_REGS-1:0]          we;
   logic [BOOT_W-1:0]            boot_q;
   logic [FLAG_W-1:0]            flags_q;
   logic [CFG_W-1:0]             cfg_q;
   logic [NUM_SW-1:0][DATA_W-1:0] sw_q;
   logic [NUM_REGS-1:0][DATA_W-1:0] words;

   assign any_rst = !por_n || !rst_n || !wdog_n;

   sysctl_wdec #(.N(NUM_REGS)) u_wdec (
      .sel_n (sel_n),
      .wr_n  (wr_n),
      .addr  (addr),
      .hold  (any_rst),
      .we    (we)
   );

   // boot field: sampled on power-on and system reset, kept across watchdog
   always_ff @(posedge clk) begin
      if (!por_n || !rst_n)
         boot_q <= boot_pads;
   end

   sysctl_field #(.W(FLAG_W), .CLS(RST_ANY)) u_flags (
      .clk     (clk),
      .por_n   (por_n),
      .any_rst (any_rst),
      .we      (we[REG_CTRL]),
      .d       (wdata[FLAG_LSB +: FLAG_W]),
      .q       (flags_q)
   );

   sysctl_field #(.W(CFG_W), .CLS(RST_ANY)) u_cfg (
      .clk     (clk),
      .por_n   (por_n),
      .any_rst (any_rst),
      .we      (we[REG_IOCFG]),
      .d       (wdata[CFG_W-1:0]),
      .q       (cfg_q)
   );

   for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
      sysctl_field #(.W(DATA_W), .CLS(RST_POR_ONLY)) u_sw (
         .clk     (clk),
         .por_n   (por_n),
         .any_rst (any_rst),
         .we      (we[REG_SWA + i]),
         .d       (wdata),
         .q       (sw_q[i])
      );
   end

   always_comb begin
      words = '0;
      words[REG_CTRL][BOOT_W-1:0]              = boot_q;
      words[REG_CTRL][FLAG_LSB +: FLAG_W]      = flags_q;
      words[REG_IOCFG][CFG_W-1:0]              = cfg_q;
      for (int i = 0; i < NUM_SW; i++)
         words[REG_SWA + i]                    = sw_q[i];
   end

   sysctl_rdmux #(.W(DATA_W), .N(NUM_REGS)) u_rdmux (
      .sel_n (sel_n),
      .addr  (addr),
      .words (words),
      .rdata (rdata)
   );

   assign pram_ext   = flags_q[FLG_PRAM];
   assign dram_ext   = flags_q[FLG_DRAM];
   assign stop_block = flags_q[FLG_STOP];
   assign wait_block = flags_q[FLG_WAIT];
   assign iocfg      = cfg_q;
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CFG_W  = 8,
   parameter int BOOT_W = 3
) (
   input logic                          clk,
   input logic                          por_n,
   input logic                          rst_n,
   input logic                          wdog_n,
   input logic                          sel_n,
   input logic                          wr_n,
   input logic [ADDR_W-1:0]             addr,
   input logic [DATA_W-1:0]             wdata,
   input logic [DATA_W-1:0]             rdata,
   input logic                          pram_ext,
   input logic                          dram_ext,
   input logic [CFG_W-1:0]              iocfg,
   input logic [BOOT_W-1:0]             boot_q,
   input logic [1:0][DATA_W-1:0]        sw_q
);
   // R2: an unselected module drives zero
   assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!por_n)
      sel_n |-> (rdata == '0));

   // R3 / R5: a clean write to the pin-function word lands next cycle
   assert_cfg_write_R5: assert property (@(posedge clk) disable iff (!por_n)
      (!sel_n && !wr_n && addr == REG_IOCFG && rst_n && wdog_n)
      |=> (iocfg == $past(wdata[CFG_W-1:0])));

   // R8 / R10: boot field moves only under power-on or system reset
   assert_boot_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
      rst_n |=> $stable(boot_q));

   // R7 / R8 / R9: scratch words ride through non-power-on resets
   assert_sw_keep_R9: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n || !wdog_n) |=> $stable(sw_q));

   // R7 / R8: switches and pin word return to zero
   assert_sw_clear_R8: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n || !wdog_n) |=> (!pram_ext && !dram_ext && iocfg == '0));
endmodule

bind sysctl_regs sysctl_regs_chk #(
   .DATA_W(DATA_W), .CFG_W(CFG_W), .BOOT_W(BOOT_W)
) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .rst_n    (rst_n),
   .wdog_n   (wdog_n),
   .sel_n    (sel_n),
   .wr_n     (wr_n),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .pram_ext (pram_ext),
   .dram_ext (dram_ext),
   .iocfg    (iocfg),
   .boot_q   (boot_q),
   .sw_q     (sw_q)
);

// File: tb/sysctl_regs_tb.sv
`timescale 1ns/1ps
module sysctl_regs_tb;
   logic        clk = 1'b0;
   logic        por_n = 1'b0, rst_n = 1'b1, wdog_n = 1'b1;
   logic [2:0]  boot_pads = 3'b101;
   logic        sel_n = 1'b1, wr_n = 1'b1;
   logic [1:0]  addr = 2'd0;
   logic [15:0] wdata = 16'h0;
   logic [15:0] rdata;
   logic        pram_ext, dram_ext, stop_block, wait_block;
   logic [7:0]  iocfg;

   typedef struct {
      bit          is_out;
      logic [15:0] exp;
      string       req;
   } item_t;

   item_t q_exp[$];
   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sysctl_regs u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .wdog_n(wdog_n),
      .boot_pads(boot_pads), .sel_n(sel_n), .wr_n(wr_n), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pram_ext(pram_ext), .dram_ext(dram_ext),
      .stop_block(stop_block), .wait_block(wait_block), .iocfg(iocfg)
   );

   // monitor: samples 1.25 ns before the next rising edge
   initial begin
      forever begin
         @(negedge clk);
         #1.25;
         while (q_exp.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q_exp.pop_front();
            act = it.is_out ? {4'b0, wait_block, stop_block, dram_ext, pram_ext, iocfg}
                            : rdata;
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: %s actual %h expected %h", it.req,
                        it.is_out ? "outputs" : "rdata", act, it.exp);
            end
         end
      end
   end

   task automatic idle();
      sel_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
      @(negedge clk);
      idle();
   endtask

   task automatic rd(input logic [1:0] a, input logic [15:0] e, input string r);
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b1; addr = a;
      q_exp.push_back('{is_out: 1'b0, exp: e, req: r});
      @(negedge clk);
      idle();
   endtask

   task automatic chk_out(input logic [15:0] e, input string r);
      @(negedge clk);
      q_exp.push_back('{is_out: 1'b1, exp: e, req: r});
   endtask

   // unselected cycle with the write strobe low; rdata must stay zero
   task automatic wr_unsel(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      sel_n = 1'b1; wr_n = 1'b0; addr = a; wdata = d;
      q_exp.push_back('{is_out: 1'b0, exp: 16'h0, req: "R2"});
      @(negedge clk);
      idle();
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         0: por_n = 1'b0;
         1: rst_n = 1'b0;
         default: wdog_n = 1'b0;
      endcase
      @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1; wdog_n = 1'b1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      // R6: power-on state, boot field from pads 101
      rd(2'd0, 16'h0005, "R6");
      rd(2'd1, 16'h0000, "R6");
      rd(2'd2, 16'h0000, "R6");
      rd(2'd3, 16'h0000, "R6");
      chk_out(16'h0000, "R6");
      // R4 R10: all-ones write sets the switches and leaves boot bits alone
      wr(2'd0, 16'hFFFF);
      rd(2'd0, 16'h007D, "R4");
      chk_out(16'h0F00, "R4");
      // R5: only the low byte is kept
      wr(2'd1, 16'hA5C3);
      rd(2'd1, 16'h00C3, "R5");
      chk_out(16'h0FC3, "R5");
      // R1: scratch words
      wr(2'd2, 16'h1234);
      wr(2'd3, 16'hBEEF);
      rd(2'd2, 16'h1234, "R1");
      rd(2'd3, 16'hBEEF, "R1");
      // R2: unselected write is ignored
      wr_unsel(2'd2, 16'hFFFF);
      rd(2'd2, 16'h1234, "R2");
      // R3: reads do not modify; single-bit write
      rd(2'd1, 16'h00C3, "R3");
      wr(2'd0, 16'h0008);
      rd(2'd0, 16'h000D, "R3");
      chk_out(16'h01C3, "R3");
      // R8: watchdog keeps boot and scratch, pads changed meanwhile
      boot_pads = 3'b010;
      pulse(2);
      rd(2'd0, 16'h0005, "R8");
      rd(2'd1, 16'h0000, "R8");
      rd(2'd2, 16'h1234, "R8");
      chk_out(16'h0000, "R8");
      // R7: system reset reloads boot, clears switches, keeps scratch
      wr(2'd0, 16'h0070);
      wr(2'd1, 16'h003C);
      chk_out(16'h0E3C, "R4");
      pulse(1);
      rd(2'd0, 16'h0002, "R7");
      rd(2'd1, 16'h0000, "R7");
      rd(2'd3, 16'hBEEF, "R7");
      chk_out(16'h0000, "R7");
      // R9: write during a reset is dropped
      @(negedge clk);
      rst_n = 1'b0; sel_n = 1'b0; wr_n = 1'b0; addr = 2'd2; wdata = 16'h5555;
      @(negedge clk);
      rst_n = 1'b1; idle();
      rd(2'd2, 16'h1234, "R9");
      // R10: writes to boot bits have no effect
      wr(2'd0, 16'h0007);
      rd(2'd0, 16'h0002, "R10");
      // R6: power-on clears scratch and resamples pads
      boot_pads = 3'b111;
      pulse(0);
      rd(2'd0, 16'h0007, "R6");
      rd(2'd2, 16'h0000, "R6");
      repeat (2) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule